// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block turns simple read and write requests into the command traffic that a small serial EEPROM with two-byte addressing expects. A master on the request side presents an operation, a 16-bit start address and a byte count. Write data is pulled one byte at a time through a valid/ready stream, and read data is pushed out one byte at a time with a single-cycle strobe. The block contains its own byte shifter and drives the SPI clock, data-out and active-low chip select directly. It uses mode 0: the clock idles low and the most significant bit goes first.

A write runs in three phases. First, a write-enable command goes out in a chip-select frame of its own. Next, the write command, both address bytes and all the data bytes go out in a single frame. Last, the block reads the status register repeatedly until the device reports that it is no longer busy. A read is one frame: the command and address, then one filler byte for each data byte wanted. The block does not split transfers at page boundaries. It does not issue status-register writes or write-disable commands.

Top module: `spi_eeprom_seq`

## Requirements
- R1: While reset is high and after it is released, spi_cs_n is 1, spi_sclk is 0, and busy, done, wr_ready and rd_valid are all 0.
- R2: A request is taken on a clock edge where req_valid is 1 and busy is 0. From the following cycle, busy stays 1 until completion. done is high for exactly one cycle, with busy still 1, and busy is 0 in the cycle after. A request presented while busy is 1, including the done cycle, is ignored.
- R3: Each SPI byte is eight clock pulses, most significant bit first. The clock idles low and is low whenever spi_cs_n is 1. spi_mosi changes only while spi_sclk is low, and spi_miso is sampled as spi_sclk rises. Each high phase of spi_sclk lasts CLK_HALF clock cycles.
- R4: A write begins with a frame that holds the single byte 0x06. spi_cs_n then stays high for at least CS_GAP cycles before the next frame, and every later frame boundary inside the operation keeps the same gap.
- R5: The second frame of a write carries 0x02, then address bits 15:8, then address bits 7:0, then the req_len data bytes in stream order, all under one chip-select assertion.
- R6: wr_ready is 1 only while the sequencer is waiting for the next write byte. A byte transfers on an edge with wr_valid and wr_ready both 1. While wr_valid is 0, the frame pauses with spi_sclk low and spi_cs_n low.
- R7: After the write frame, the block sends status frames of two bytes, 0x05 then 0x00. The byte received in the second position is the status. A new status frame follows after the gap while status bit 0 is 1, and done comes only after a status whose bit 0 is 0.
- R8: A read is one frame holding 0x03, address bits 15:8, address bits 7:0, and then req_len bytes of 0x00. Each byte received during the filler bytes appears on rd_data with a one-cycle rd_valid. Bytes received during the command and address produce no rd_valid.
- R9: The rd_valid of the last byte of a read falls in the same cycle as done.
- R10: A request with req_len equal to 0 produces done without any chip-select frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Start byte address |
| req_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Two events can land in the same cycle. The first is the strobe for the final read byte and the completion pulse. The bench checks on every read length that the last rd_valid and done are high together, and that no earlier byte shows done. The second is a new request arriving while done is high. Some runs hold a different, conflicting request on req_valid through the whole operation and the done cycle. The bench then confirms that busy falls, no new frame starts, and the device model saw only the frames of the original operation.

// File: rtl/spi_eeprom_seq_pkg.sv
package spi_eeprom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP,
    ST_HDR,
    ST_WAIT_WR,
    ST_WDATA,
    ST_RDATA,
    ST_POLL,
    ST_DONE
  } seq_state_e;

  localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
  localparam logic [7:0] OPC_WRITE     = 8'h02;
  localparam logic [7:0] OPC_READ      = 8'h03;
  localparam logic [7:0] OPC_STATUS    = 8'h05;
  localparam logic [7:0] FILL_BYTE     = 8'h00;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);

  localparam int HW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(CLK_HALF - 1);

  logic          running;
  logic [HW-1:0] half_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic          sclk_q;
  logic          mosi_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (start) begin
          running  <= 1'b1;
          sh_tx    <= tx_byte;
          mosi_q   <= tx_byte[7];
          half_cnt <= HALF_LAST;
          bit_idx  <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (half_cnt != '0) begin
        half_cnt <= half_cnt - 1'b1;
      end else begin
        half_cnt <= HALF_LAST;
        if (!sclk_q) begin
          // rising edge: capture the device's bit
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], miso};
        end else begin
          // falling edge: present the next bit or close the byte
          sclk_q <= 1'b0;
          if (bit_idx == 3'd7) begin
            running <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
            mosi_q  <= sh_tx[6];
          end
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign byte_done = done_q;
  assign rx_byte   = sh_rx;

  // R3: data line holds while the clock is high
  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));

  // R3: the controller never launches a byte into a running shifter
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    start |-> !running);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import spi_eeprom_seq_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int CS_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             eng_start,
  output logic [7:0]       eng_tx,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx
);

  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  seq_state_e       state;
  logic             op_wr;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] remain;
  logic [1:0]       hdr_idx;
  logic             poll_idx;
  logic [GW-1:0]    gap_cnt;
  logic             gap_to_poll;
  logic             in_flight;
  logic [7:0]       status_q;
  logic [7:0]       hdr_byte;

  logic             cs_n_q, busy_q, done_q, rd_valid_q, wr_ready_q, eng_start_q;
  logic [7:0]       rd_data_q, eng_tx_q;

  always_comb begin
    case (hdr_idx)
      2'd0:    hdr_byte = op_wr ? OPC_WRITE : OPC_READ;
      2'd1:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_wr       <= 1'b0;
      addr_q      <= '0;
      remain      <= '0;
      hdr_idx     <= '0;
      poll_idx    <= 1'b0;
      gap_cnt     <= '0;
      gap_to_poll <= 1'b0;
      in_flight   <= 1'b0;
      status_q    <= '0;
      cs_n_q      <= 1'b1;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      wr_ready_q  <= 1'b0;
      eng_start_q <= 1'b0;
      eng_tx_q    <= '0;
    end else begin
      eng_start_q <= 1'b0;
      done_q      <= 1'b0;
      rd_valid_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            busy_q   <= 1'b1;
            op_wr    <= req_write;
            addr_q   <= req_addr;
            remain   <= req_len;
            hdr_idx  <= '0;
            poll_idx <= 1'b0;
            status_q <= '0;
            if (req_len == '0) begin
              done_q <= 1'b1;
              state  <= ST_DONE;
            end else begin
              cs_n_q <= 1'b0;
              state  <= req_write ? ST_WREN : ST_HDR;
            end
          end
        end
        ST_WREN: begin
          if (eng_done) begin
            in_flight   <= 1'b0;
            cs_n_q      <= 1'b1;
            gap_cnt     <= GAP_LAST;
            gap_to_poll <= 1'b0;
            state       <= ST_GAP;
          end else if (!in_flight) begin
            eng_start_q <= 1'b1;
            eng_tx_q    <= OPC_WR_ENABLE;
            in_flight   <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            cs_n_q <= 1'b0;
            state  <= gap_to_poll ? ST_POLL : ST_HDR;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_HDR: begin
          if (eng_done) begin
            in_flight <= 1'b0;
            if (hdr_idx == 2'd2) begin
              if (op_wr) begin
                wr_ready_q <= 1'b1;
                state      <= ST_WAIT_WR;
              end else begin
                state <= ST_RDATA;
              end
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end else if (!in_flight) begin
            eng_start_q <= 1'b1;
            eng_tx_q    <= hdr_byte;
            in_flight   <= 1'b1;
          end
        end
        ST_WAIT_WR: begin
          if (wr_valid) begin
            wr_ready_q  <= 1'b0;
            eng_start_q <= 1'b1;
            eng_tx_q    <= wr_data;
            state       <= ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (eng_done) begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) begin
              cs_n_q      <= 1'b1;
              gap_cnt     <= GAP_LAST;
              gap_to_poll <= 1'b1;
              poll_idx    <= 1'b0;
              state       <= ST_GAP;
            end else begin
              wr_ready_q <= 1'b1;
              state      <= ST_WAIT_WR;
            end
          end
        end
        ST_RDATA: begin
          if (eng_done) begin
            in_flight  <= 1'b0;
            rd_valid_q <= 1'b1;
            rd_data_q  <= eng_rx;
            remain     <= remain - 1'b1;
            if (remain == LEN_W'(1)) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_DONE;
            end
          end else if (!in_flight) begin
            eng_start_q <= 1'b1;
            eng_tx_q    <= FILL_BYTE;
            in_flight   <= 1'b1;
          end
        end
        ST_POLL: begin
          if (eng_done) begin
            in_flight <= 1'b0;
            if (!poll_idx) begin
              poll_idx <= 1'b1;
            end else begin
              status_q <= eng_rx;
              cs_n_q   <= 1'b1;
              if (eng_rx[0]) begin
                gap_cnt     <= GAP_LAST;
                gap_to_poll <= 1'b1;
                poll_idx    <= 1'b0;
                state       <= ST_GAP;
              end else begin
                done_q <= 1'b1;
                state  <= ST_DONE;
              end
            end
          end else if (!in_flight) begin
            eng_start_q <= 1'b1;
            eng_tx_q    <= poll_idx ? FILL_BYTE : OPC_STATUS;
            in_flight   <= 1'b1;
          end
        end
        ST_DONE: begin
          busy_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n      = cs_n_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign wr_ready  = wr_ready_q;
  assign eng_start = eng_start_q;
  assign eng_tx    = eng_tx_q;

  // R7: a write never finishes on a status that still reports busy
  a_r7_idle_status: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && op_wr) |-> !status_q[0]);

  // R10: an empty request reaches completion without opening a frame
  a_r10_no_frame: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req_valid && req_len == '0) |=> cs_n_q);

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int CLK_HALF = 4,
  parameter int CS_GAP   = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);

  logic       eng_start;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic [7:0] eng_rx;

  seq_ctrl #(
    .LEN_W  (LEN_W),
    .CS_GAP (CS_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .done      (done),
    .cs_n      (spi_cs_n),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx)
  );

  spi_byte_shifter #(
    .CLK_HALF (CLK_HALF)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .tx_byte   (eng_tx),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .byte_done (eng_done),
    .rx_byte   (eng_rx)
  );

  // R2: completion is flagged while still busy, and busy drops right after
  a_r2_done_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r2_busy_falls: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R3: clock stays low outside a frame
  a_r3_idle_clock: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R6: write handshake only offered inside an open frame
  a_r6_ready_frame: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (busy && !spi_cs_n && !spi_sclk));

  // R8: read strobes only during an operation
  a_r8_rd_in_op: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

endmodule

// File: tb/spi_eeprom_seq_bench.sv
module spi_eeprom_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HALF   = 2;
  localparam int CS_GAP     = 3;
  localparam int LEN_W      = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [15:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]       wr_data = '0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             busy;
  logic             done;
  logic             spi_sclk;
  logic             spi_mosi;
  logic             spi_miso = 1'b0;
  logic             spi_cs_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_seq #(
    .CLK_HALF (CLK_HALF),
    .CS_GAP   (CS_GAP),
    .LEN_W    (LEN_W)
  ) u_spi_eeprom_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .done      (done),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0]  m_mem [256];
  logic [7:0]  m_sh = '0;
  logic [7:0]  m_osh = '0;
  logic [7:0]  m_cmd = '0;
  logic [15:0] m_addr = '0;
  logic [15:0] m_hdr_addr = '0;
  logic        m_wel = 1'b0;
  int m_bits = 0, m_bytes = 0, m_busy_left = 0, busy_load = 0;
  int n_frames = 0, n_wren = 0, n_wrframe = 0, n_rdframe = 0, n_poll = 0;
  int n_written = 0, n_unarmed = 0, n_bad_tx = 0, n_bad_frame = 0;

  task automatic model_byte(input logic [7:0] b);
    logic [7:0] nxt;
    nxt = 8'h00;
    if (m_bytes == 0) begin
      m_cmd = b;
      if (b == 8'h05) nxt = {6'b0, m_wel, (m_busy_left != 0)};
    end else if (m_cmd == 8'h02 || m_cmd == 8'h03) begin
      if (m_bytes == 1) m_addr[15:8] = b;
      else if (m_bytes == 2) begin
        m_addr[7:0] = b;
        m_hdr_addr = m_addr;
        if (m_cmd == 8'h03) nxt = m_mem[m_addr[7:0]];
      end else if (m_cmd == 8'h02) begin
        if (m_wel) begin m_mem[m_addr[7:0]] = b; n_written++; end
        else n_unarmed++;
        m_addr = m_addr + 16'd1;
      end else begin
        if (b != 8'h00) n_bad_tx++;
        m_addr = m_addr + 16'd1;
        nxt = m_mem[m_addr[7:0]];
      end
    end
    m_osh = nxt;
  endtask

  always @(negedge spi_cs_n) begin
    m_bits = 0; m_bytes = 0; m_cmd = 8'h00; n_frames++;
  end

  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    m_sh = {m_sh[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_bits = 0;
      model_byte(m_sh);
      m_bytes++;
    end
  end

  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
    spi_miso <= m_osh[7];
    m_osh = {m_osh[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) begin
    if (m_bits != 0) n_bad_frame++;
    case (m_cmd)
      8'h06: if (m_bytes == 1) begin m_wel = 1'b1; n_wren++; end else n_bad_frame++;
      8'h02: if (m_bytes >= 3) begin n_wrframe++; m_wel = 1'b0; m_busy_left = busy_load; end
      8'h03: n_rdframe++;
      8'h05: begin n_poll++; if (m_busy_left > 0) m_busy_left--; end
      default: ;
    endcase
  end

  // ---------------- line monitors (R3, R4) ----------------
  int hi_run = 0, bad_half = 0, gap_run = 0, bad_gap = 0;
  logic prev_sclk = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (spi_sclk) hi_run++;
    else if (prev_sclk) begin
      if (hi_run != CLK_HALF) bad_half++;
      hi_run = 0;
    end
    prev_sclk = spi_sclk;
    if (!busy) gap_run = 0;
    else if (spi_cs_n) gap_run++;
    else begin
      if (gap_run > 0 && gap_run < CS_GAP) bad_gap++;
      gap_run = 0;
    end
  end

  // ---------------- expected contents ----------------
  logic [7:0] exp_mem [256];
  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 13 + seed) & 255);
  endfunction

  task automatic clear_model_counts();
    n_frames = 0; n_wren = 0; n_wrframe = 0; n_rdframe = 0; n_poll = 0;
    n_written = 0; n_unarmed = 0; n_bad_tx = 0; n_bad_frame = 0;
  endtask

  task automatic run_op(input bit wr, input logic [15:0] addr, input int len,
                        input int seed, input bit stall, input bit hold);
    int cycles, widx, got, stall_err, frames_at_done;
    bit took, early_drop;
    clear_model_counts();
    busy_load = len % 4;
    cycles = 0; widx = 0; got = 0; stall_err = 0; early_drop = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = LEN_W'(len);
    @(posedge clk);
    forever begin
      @(negedge clk);
      cycles++;
      if (hold) begin
        req_valid = 1'b1; req_write = !wr; req_addr = 16'h7F00; req_len = LEN_W'(3);
      end else req_valid = 1'b0;
      if (!busy) early_drop = 1;
      if (wr_ready && spi_sclk) stall_err++;
      if (rd_valid) begin
        check(rd_data == exp_mem[8'((int'(addr) + got) & 255)], "R8 read byte",
              int'(rd_data), int'(exp_mem[8'((int'(addr) + got) & 255)]));
        got++;
        check(done == (got == len), "R9 last byte with done", int'(done), int'(got == len));
      end else if (done && !wr && len > 0) begin
        check(1'b0, "R9 done without final byte", 0, 1);
      end
      wr_valid = !(stall && (cycles % 3 == 0));
      wr_data  = pat(int'(addr) + widx, seed);
      took = wr_ready && wr_valid;
      if (done) break;
      if (took) widx++;
      if (cycles > 20000) begin
        check(1'b0, "R2 operation timeout", cycles, 20000);
        break;
      end
    end
    frames_at_done = n_frames;
    check(!early_drop, "R2 busy held until done", int'(early_drop), 0);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy low after done", int'(busy), 0);
    req_valid = 1'b0; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && n_frames == frames_at_done, "R2 held request ignored",
          n_frames, frames_at_done);
    if (len == 0) begin
      check(n_frames == 0, "R10 no frame for empty request", n_frames, 0);
      check(cycles == 1, "R10 immediate done", cycles, 1);
    end else if (wr) begin
      check(n_wren == 1, "R4 single write-enable frame", n_wren, 1);
      check(n_unarmed == 0, "R4 write armed by enable", n_unarmed, 0);
      check(n_wrframe == 1, "R5 one write frame", n_wrframe, 1);
      check(m_hdr_addr == addr, "R5 address bytes", int'(m_hdr_addr), int'(addr));
      check(n_written == len, "R5 data bytes in frame", n_written, len);
      check(widx == len, "R6 stream bytes taken", widx, len);
      check(stall_err == 0, "R6 pause with clock low", stall_err, 0);
      check(n_poll == busy_load + 1, "R7 status polls", n_poll, busy_load + 1);
      check(n_frames == busy_load + 3, "R7 frame count", n_frames, busy_load + 3);
      for (int i = 0; i < len; i++)
        exp_mem[8'((int'(addr) + i) & 255)] = pat(int'(addr) + i, seed);
    end else begin
      check(n_frames == 1 && n_rdframe == 1, "R8 single read frame", n_frames, 1);
      check(m_hdr_addr == addr, "R8 address bytes", int'(m_hdr_addr), int'(addr));
      check(n_bad_tx == 0, "R8 filler bytes zero", n_bad_tx, 0);
      check(got == len, "R8 byte count", got, len);
    end
    check(n_bad_frame == 0, "R3 whole bytes per frame", n_bad_frame, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stimulus
    for (int i = 0; i < 256; i++) begin m_mem[i] = 8'hA5; exp_mem[i] = 8'hA5; end
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 lines in reset", int'({spi_cs_n, spi_sclk}), 2);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 chip select idle", int'(spi_cs_n), 1);
    check(spi_sclk == 1'b0, "R1 clock idle", int'(spi_sclk), 0);
    check(busy == 1'b0 && done == 1'b0, "R1 busy and done low", int'({busy, done}), 0);
    check(wr_ready == 1'b0 && rd_valid == 1'b0, "R1 streams idle", int'({wr_ready, rd_valid}), 0);

    // R10: empty requests
    run_op(1'b1, 16'h1234, 0, 1, 1'b0, 1'b0);
    run_op(1'b0, 16'h1234, 0, 1, 1'b0, 1'b1);

    // sweep of write then read back, lengths 1..9
    for (int len = 1; len <= 9; len++) begin
      logic [15:0] a;
      a = {8'((len * 37 + 3) & 255), 8'((len * 23) & 255)};
      run_op(1'b1, a, len, len * 11, len[0], len % 3 == 0);
    end
    for (int len = 1; len <= 9; len++) begin
      logic [15:0] a;
      a = {8'((len * 37 + 3) & 255), 8'((len * 23) & 255)};
      run_op(1'b0, a, len, 0, 1'b0, len % 3 == 1);
    end
    // overwrite part of an earlier region, read the merged result
    run_op(1'b1, 16'h4A30, 4, 99, 1'b1, 1'b0);
    run_op(1'b0, 16'h4A2E, 8, 0, 1'b0, 1'b1);

    check(bad_half == 0, "R3 clock high phase length", bad_half, 0);
    check(bad_gap == 0, "R4 chip select gap", bad_gap, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule